// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block models the control side of a single-port synchronous burst SRAM. On every rising clock edge it samples three chip selects, two address strobes, a burst-advance input, the write controls and a sleep input. From these it decides whether the cycle deselects the device, loads the external address and starts a read or a write, steps to the next burst address, or repeats the current one. It owns a 64-word array that can be written one byte lane at a time, and a registered read path whose drive enable is gated by an asynchronous output enable.

The data bus is brought out as pad-control signals: `dq_in` carries what is on the pins, `dq_out` the value the block would drive, and `dq_oe` the tri-state enable for the pad ring. A deasserted `dq_oe` means the bus floats. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the merged write level. Once a cycle is open, the strobes can stay inactive and the burst-advance input chooses step or suspend on each clock. The write controls then turn the continuing cycle into a read or a write.

Top module: `burst_sram_ctrl`

## Requirements
- R1: With `sleep` low, `pstrb_n` low and the chip fully selected (`sel1_n` low, `sel2` high, `sel3_n` low), the edge loads `addr_in` and opens a read cycle. This happens whatever `gwr_n`, `bwr_n` and `lane_wr_n` are.
- R2: While `sel1_n` is high, `pstrb_n` is ignored, and an open cycle carries on as if no strobe were present. A low `cstrb_n` with `sel1_n` high deselects the device.
- R3: An effective strobe (`cstrb_n` low, or `pstrb_n` low with `sel1_n` low) while `sel2` is low or `sel3_n` is high deselects the device. After that edge `dq_oe` is 0 even with `oe_n` low.
- R4: With `pstrb_n` high, `cstrb_n` low and the chip fully selected, the edge loads `addr_in`. It opens a read if the merged write level is high and a write if it is low. A write stores `dq_in` at `addr_in` on that edge.
- R5: The merged write level is low when `gwr_n` is low, or when `bwr_n` is low together with at least one bit of `lane_wr_n`. Lane g (data bits 8g+7..8g) is stored when `gwr_n` is low, or when `bwr_n` and `lane_wr_n[g]` are both low. When the level is high, nothing is stored.
- R6: With no effective strobe, an open cycle and `adv_n` low, the two lowest address bits count up by one and wrap inside an aligned four-word block. The upper address bits keep their loaded value.
- R7: With no effective strobe, an open cycle and `adv_n` high, the address is held, so the same word is read or written again.
- R8: No write happens on an edge where `pstrb_n` is low with `sel1_n` low. A write may follow on the next edge at the held address, through the write controls alone.
- R9: Read data for an address that is registered on edge N appears on `dq_out` after edge N+1. `dq_oe` is 0 between N and N+1.
- R10: `oe_n` acts on `dq_oe` without a clock edge. During a read cycle with data ready, `dq_oe` follows the inverse of `oe_n`.
- R11: While the registered cycle is a write, `dq_oe` is 0 whatever `oe_n` is, and the first cycle after a write presents no data.
- R12: While `sleep` is high, `dq_oe` is 0, no write occurs and no cycle starts. Sleep closes any open cycle, and the array contents survive.
- R13: While `rst_n` is low, and after its release with no strobe, no cycle is open and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sleep | input | 1 | High: all other inputs ignored, bus floats |
| sel1_n | input | 1 | Chip select, active low; also qualifies the processor strobe |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| pstrb_n | input | 1 | Processor address strobe, active low, always reads |
| cstrb_n | input | 1 | Controller address strobe, active low, reads or writes |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| gwr_n | input | 1 | Write of all lanes, active low |
| bwr_n | input | 1 | Byte-write master enable, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr_in | input | 6 | External word address |
| dq_in | input | 32 | Data seen on the bus pins |
| dq_out | output | 32 | Registered read data toward the pads |
| dq_oe | output | 1 | Pad drive enable; 0 means the bus floats |

## Verification
The bench aims at the places where the two strobes differ. A processor strobe with the write controls active must not store anything; a design that lets it write would corrupt the word. A processor strobe with `sel1_n` high must not reload the address; if it did, a held read would switch to another word. The burst is walked across the end of its four-word block, where a carry into the upper bits would return the word that follows the block instead of its first word. The bench also checks the output mask right after a write, the asynchronous response to `oe_n`, partial lane writes, and the case where the merged write level is high so no write takes place. A sleep period that tries a write must leave the array unchanged and the cycle closed.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_RD   = 2'b01,
      OP_WR   = 2'b10
   } op_e;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_DESEL = 3'd1,
      CMD_LOAD  = 3'd2,
      CMD_STEP  = 3'd3,
      CMD_HOLD  = 3'd4
   } cmd_e;

endpackage

// File: rtl/bsram_wmerge.sv
module bsram_wmerge #(
   parameter int LANES = 4
) (
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic [LANES-1:0] lane_en,
   output logic             wr_n
);

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         assign lane_en[g] = !gwr_n || (!bwr_n && !lane_wr_n[g]);
      end
   endgenerate

   // merged level is low when any lane would be stored
   assign wr_n = !(|lane_en);

endmodule

// File: rtl/bsram_ctl.sv
module bsram_ctl
   import bsram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   input  logic sel1_n,
   input  logic sel2,
   input  logic sel3_n,
   input  logic pstrb_n,
   input  logic cstrb_n,
   input  logic adv_n,
   input  logic wr_n,
   output cmd_e cmd,
   output op_e  op_q,
   output logic mem_we
);

   logic psel;
   logic strobe;
   logic chip_on;
   op_e  nxt_op;

   assign psel    = !pstrb_n && !sel1_n;
   assign strobe  = psel || !cstrb_n;
   assign chip_on = !sel1_n && sel2 && !sel3_n;

   always_comb begin
      cmd    = CMD_NOP;
      nxt_op = OP_IDLE;
      if (!sleep) begin
         if (strobe) begin
            if (chip_on) begin
               cmd    = CMD_LOAD;
               nxt_op = (psel || wr_n) ? OP_RD : OP_WR;
            end else begin
               cmd    = CMD_DESEL;
            end
         end else if (op_q != OP_IDLE) begin
            cmd    = adv_n ? CMD_HOLD : CMD_STEP;
            nxt_op = wr_n ? OP_RD : OP_WR;
         end
      end
   end

   assign mem_we = (nxt_op == OP_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) op_q <= OP_IDLE;
      else        op_q <= nxt_op;
   end

   // R12: a sleeping edge never opens a cycle
   a_r12_sleep_closes: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (op_q == OP_IDLE));

endmodule

// File: rtl/bsram_addr.sv
module bsram_addr
   import bsram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_nxt,
   output logic [ADDR_W-1:0] addr_q
);

   logic [ADDR_W-1:0] stepped;

   generate
      if (BURST_W >= ADDR_W) begin : g_full
         assign stepped = addr_q + ADDR_W'(1);
      end else begin : g_split
         logic [BURST_W-1:0] low_inc;
         assign low_inc = addr_q[BURST_W-1:0] + BURST_W'(1);
         assign stepped = {addr_q[ADDR_W-1:BURST_W], low_inc};
      end
   endgenerate

   always_comb begin
      case (cmd)
         CMD_LOAD: addr_nxt = addr_in;
         CMD_STEP: addr_nxt = stepped;
         default:  addr_nxt = addr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_nxt;
   end

   // R7: a suspend keeps the registered address
   a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_HOLD) |=> $stable(addr_q));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_en,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we && lane_en[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
         end

         assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/bsram_oreg.sv
module bsram_oreg
   import bsram_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              oe_n,
   input  op_e               op_q,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   logic ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         dq_out  <= '0;
      end else begin
         ready_q <= (op_q == OP_RD) && !sleep;
         if (op_q == OP_RD) dq_out <= rdata;
      end
   end

   // enable is combinational in oe_n and sleep; writes and idle mask it
   assign dq_oe = ready_q && (op_q == OP_RD) && !oe_n && !sleep;

   // R11: never drive during a registered write
   a_r11_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WR) |-> !dq_oe);

   // R9: the first cycle of a fresh read presents nothing
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_q == OP_IDLE) || (op_q == OP_WR)) |=> !dq_oe);

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
   import bsram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2,
   parameter int LANES   = 4,
   parameter int LANE_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sleep,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    sel3_n,
   input  logic                    pstrb_n,
   input  logic                    cstrb_n,
   input  logic                    adv_n,
   input  logic                    gwr_n,
   input  logic                    bwr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    oe_n,
   input  logic [ADDR_W-1:0]       addr_in,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
         $error("burst_sram_ctrl: ADDR_W must lie in 1..12");
      end
      if (BURST_W < 1 || BURST_W > ADDR_W) begin : g_bad_bw
         $error("burst_sram_ctrl: BURST_W must lie in 1..ADDR_W");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("burst_sram_ctrl: LANES and LANE_W must be positive");
      end
   endgenerate

   logic [LANES-1:0]  lane_en;
   logic              wr_n;
   cmd_e              cmd;
   op_e               op_q;
   logic              mem_we;
   logic [ADDR_W-1:0] addr_nxt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] rdata;

   bsram_wmerge #(.LANES(LANES)) u_merge (
      .gwr_n     (gwr_n),
      .bwr_n     (bwr_n),
      .lane_wr_n (lane_wr_n),
      .lane_en   (lane_en),
      .wr_n      (wr_n)
   );

   bsram_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep   (sleep),
      .sel1_n  (sel1_n),
      .sel2    (sel2),
      .sel3_n  (sel3_n),
      .pstrb_n (pstrb_n),
      .cstrb_n (cstrb_n),
      .adv_n   (adv_n),
      .wr_n    (wr_n),
      .cmd     (cmd),
      .op_q    (op_q),
      .mem_we  (mem_we)
   );

   bsram_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .addr_in  (addr_in),
      .addr_nxt (addr_nxt),
      .addr_q   (addr_q)
   );

   bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .we      (mem_we),
      .lane_en (lane_en),
      .waddr   (addr_nxt),
      .wdata   (dq_in),
      .raddr   (addr_q),
      .rdata   (rdata)
   );

   bsram_oreg #(.DATA_W(DATA_W)) u_oreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .sleep  (sleep),
      .oe_n   (oe_n),
      .op_q   (op_q),
      .rdata  (rdata),
      .dq_out (dq_out),
      .dq_oe  (dq_oe)
   );

   // R1: processor strobe on a selected chip opens a read at the pins' address
   a_r1_pstrb_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !pstrb_n && !sel1_n && sel2 && !sel3_n)
      |=> (op_q == OP_RD) && (addr_q == $past(addr_in)));

   // R2: controller strobe with sel1_n high deselects
   a_r2_cstrb_sel1_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !cstrb_n && sel1_n) |=> (op_q == OP_IDLE));

   // R3: a strobe on a partly selected chip deselects and floats the bus
   a_r3_desel_floats: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && ((!pstrb_n && !sel1_n) || !cstrb_n) && (!sel2 || sel3_n))
      |=> (op_q == OP_IDLE) && !dq_oe);

   // R4: controller strobe with an active write level opens a write
   a_r4_cstrb_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && pstrb_n && !cstrb_n && !sel1_n && sel2 && !sel3_n && !gwr_n)
      |=> (op_q == OP_WR) && (addr_q == $past(addr_in)));

   // R6: burst step counts the low bits and keeps the upper bits
   a_r6_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && pstrb_n && cstrb_n && !adv_n && (op_q != OP_IDLE))
      |=> (addr_q[BURST_W-1:0] == BURST_W'($past(addr_q[BURST_W-1:0]) + 1'b1))
          && ((addr_q >> BURST_W) == ($past(addr_q) >> BURST_W)));

   // R8: no store on an edge where the processor strobe counts
   a_r8_no_pstrb_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstrb_n && !sel1_n) |-> !mem_we);

   // R12: sleep floats the bus and blocks stores
   a_r12_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (!dq_oe && !mem_we));

endmodule

// File: tb/sim_burst_sram_ctrl.sv
`timescale 1ns/1ps
module sim_burst_sram_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sleep, sel1_n, sel2, sel3_n, pstrb_n, cstrb_n, adv_n;
   logic        gwr_n, bwr_n, oe_n;
   logic [3:0]  lane_wr_n;
   logic [5:0]  addr_in;
   logic [31:0] dq_in;
   logic [31:0] dq_out;
   logic        dq_oe;

   int total = 0;
   int bad   = 0;
   logic [31:0] model [64];

   always #4 clk = ~clk;

   burst_sram_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel1_n(sel1_n), .sel2(sel2),
      .sel3_n(sel3_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
      .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
      .addr_in(addr_in), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_in();
      sleep = 0; sel1_n = 0; sel2 = 1; sel3_n = 0;
      pstrb_n = 1; cstrb_n = 1; adv_n = 1;
      gwr_n = 1; bwr_n = 1; lane_wr_n = 4'hF; oe_n = 1;
      addr_in = '0; dq_in = '0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic desel();
      cstrb_n = 0; sel2 = 0; adv_n = 1; gwr_n = 1; bwr_n = 1; lane_wr_n = 4'hF;
      tick();
      idle_in();
   endtask

   // controller-strobe write; model follows the lane rule of R5
   task automatic wr_word(input logic [5:0] a, input logic [31:0] d,
                          input logic g_n, input logic b_n, input logic [3:0] ln);
      cstrb_n = 0; addr_in = a; dq_in = d; gwr_n = g_n; bwr_n = b_n; lane_wr_n = ln;
      tick();
      for (int g = 0; g < 4; g++)
         if (!g_n || (!b_n && !ln[g])) model[a][g*8 +: 8] = d[g*8 +: 8];
      desel();
   endtask

   task automatic rd_word(input logic [5:0] a, input string req);
      pstrb_n = 0; addr_in = a; oe_n = 0;
      tick();
      chk({req, " R9 no data on load cycle"}, {31'd0, dq_oe}, 32'd0);
      pstrb_n = 1;
      tick();
      chk({req, " R9 oe after one clock"}, {31'd0, dq_oe}, 32'd1);
      chk({req, " read data"}, dq_out, model[a]);
      desel();
   endtask

   task automatic t_reset();
      rst_n = 0; idle_in(); oe_n = 0;
      repeat (3) tick();
      chk("R13 float in reset", {31'd0, dq_oe}, 32'd0);
      rst_n = 1;
      tick(); tick();
      chk("R13 float after reset", {31'd0, dq_oe}, 32'd0);
      idle_in();
   endtask

   task automatic t_cstrb_write_read();
      for (int i = 0; i < 5; i++)
         wr_word(6'h10 + 6'(i), 32'hA0000000 + 32'(i * 32'h01010101), 1'b0, 1'b1, 4'hF);
      rd_word(6'h10, "R4 write at 0x10");
      rd_word(6'h13, "R4 write at 0x13");
   endtask

   task automatic t_burst();
      pstrb_n = 0; addr_in = 6'h12; oe_n = 0;
      tick();
      pstrb_n = 1; adv_n = 0;
      tick(); chk("R6 burst word0 0x12", dq_out, model[6'h12]);
      tick(); chk("R6 burst word1 0x13", dq_out, model[6'h13]);
      tick(); chk("R6 burst wraps to 0x10", dq_out, model[6'h10]);
      tick(); chk("R6 burst word3 0x11", dq_out, model[6'h11]);
      desel();
   endtask

   task automatic t_suspend();
      pstrb_n = 0; addr_in = 6'h11; oe_n = 0;
      tick();
      pstrb_n = 1; adv_n = 1;
      tick(); chk("R7 suspend first", dq_out, model[6'h11]);
      tick(); chk("R7 suspend repeats", dq_out, model[6'h11]);
      desel();
   endtask

   task automatic t_lanes();
      wr_word(6'h20, 32'hAABBCCDD, 1'b0, 1'b1, 4'hF);
      wr_word(6'h20, 32'h11223344, 1'b1, 1'b0, 4'b1010);
      rd_word(6'h20, "R5 lanes 0 and 2 stored");
      chk("R5 partial value", model[6'h20], 32'hAA22CC44);
      wr_word(6'h20, 32'h55555555, 1'b1, 1'b1, 4'b0000);
      rd_word(6'h20, "R5 byte enables without master ignored");
   endtask

   task automatic t_pstrb_nowrite();
      wr_word(6'h21, 32'h01010101, 1'b0, 1'b1, 4'hF);
      pstrb_n = 0; addr_in = 6'h21; gwr_n = 0; dq_in = 32'hDEADBEEF;
      tick();
      desel();
      rd_word(6'h21, "R8 no store with processor strobe");
      pstrb_n = 0; addr_in = 6'h21;
      tick();
      pstrb_n = 1; gwr_n = 0; dq_in = 32'h0BADF00D;
      tick();
      model[6'h21] = 32'h0BADF00D;
      desel();
      rd_word(6'h21, "R8 write on following clock");
   endtask

   task automatic t_sel1();
      pstrb_n = 0; addr_in = 6'h20; oe_n = 0;
      tick();
      sel1_n = 1; addr_in = 6'h21;
      tick(); chk("R2 ignored strobe holds", dq_out, model[6'h20]);
      tick(); chk("R2 address not reloaded", dq_out, model[6'h20]);
      pstrb_n = 1; cstrb_n = 0;
      tick(); chk("R2 controller strobe deselects", {31'd0, dq_oe}, 32'd0);
      idle_in();
   endtask

   task automatic t_desel();
      pstrb_n = 0; addr_in = 6'h10; oe_n = 0;
      tick(); pstrb_n = 1;
      tick(); chk("R3 read active before", {31'd0, dq_oe}, 32'd1);
      pstrb_n = 0; sel2 = 0;
      tick(); chk("R3 sel2 low floats", {31'd0, dq_oe}, 32'd0);
      pstrb_n = 1; sel2 = 1;
      tick(); chk("R3 stays closed", {31'd0, dq_oe}, 32'd0);
      pstrb_n = 0; addr_in = 6'h11;
      tick(); pstrb_n = 1;
      tick();
      cstrb_n = 0; sel3_n = 1;
      tick(); chk("R3 sel3_n high floats", {31'd0, dq_oe}, 32'd0);
      idle_in();
   endtask

   task automatic t_oe_and_mask();
      wr_word(6'h30, 32'hCAFEF00D, 1'b0, 1'b1, 4'hF);
      pstrb_n = 0; addr_in = 6'h30; oe_n = 0;
      tick(); pstrb_n = 1;
      tick(); chk("R10 driven with oe low", {31'd0, dq_oe}, 32'd1);
      oe_n = 1; #1;
      chk("R10 async release", {31'd0, dq_oe}, 32'd0);
      oe_n = 0; #1;
      chk("R10 async drive", {31'd0, dq_oe}, 32'd1);
      oe_n = 1; gwr_n = 0; dq_in = 32'h13572468;
      tick();
      model[6'h30] = 32'h13572468;
      gwr_n = 1; oe_n = 0; #1;
      chk("R11 masked in write cycle", {31'd0, dq_oe}, 32'd0);
      tick(); chk("R11 no data right after write", {31'd0, dq_oe}, 32'd0);
      tick(); chk("R11 new data read back", dq_out, model[6'h30]);
      desel();
   endtask

   task automatic t_sleep();
      wr_word(6'h22, 32'h22222222, 1'b0, 1'b1, 4'hF);
      pstrb_n = 0; addr_in = 6'h22; oe_n = 0;
      tick(); pstrb_n = 1;
      tick();
      sleep = 1; #1;
      chk("R12 sleep floats at once", {31'd0, dq_oe}, 32'd0);
      cstrb_n = 0; gwr_n = 0; dq_in = 32'hFFFFFFFF;
      tick(); tick();
      chk("R12 still floating", {31'd0, dq_oe}, 32'd0);
      idle_in(); oe_n = 0;
      tick(); chk("R12 cycle closed after sleep", {31'd0, dq_oe}, 32'd0);
      idle_in();
      rd_word(6'h22, "R12 write ignored in sleep");
      rd_word(6'h10, "R12 contents kept");
   endtask

   initial begin
      t_reset();
      t_cstrb_write_read();
      t_burst();
      t_suspend();
      t_lanes();
      t_pstrb_nowrite();
      t_sel1();
      t_desel();
      t_oe_and_mask();
      t_sleep();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule